// File: doc/BRIEF.md
# Emergency-Aware Thread Migration Controller

This block watches the timing health of the four cores of a processor and proposes one thread exchange per migration interval. Each core gives it two inputs. The first is a pulse in every cycle in which a timing emergency occurred. The second is a delay-sensor reading, which arrives with its own valid flag about every ten cycles. Over each interval the block counts every core's emergencies and accumulates its delay readings. The accumulated delay acts as a low-pass estimate of the slow process-and-temperature part of that core's timing. Fast supply noise averages out in this sum and needs no separate estimate.

At each interval boundary the count for the interval just ended is stored. The count from the interval before it is kept as history. A linear extrapolation, twice the newest count minus the previous count, gives the expected emergency level for the coming interval. The core with the highest expected level is the source, and the core with the smallest delay sum is the destination. The controller then emits a one-cycle request to exchange the threads of those two cores. It emits no request when the exchange would be pointless: source and destination are the same core, or no core is expected to see any emergency.

The interval length comes in on an input port. A typical setting is 400,000 cycles, which is 0.2 ms at 2 GHz. Longer settings lower the relative cost of each migration. Because every core is measured over the same window, raw counts and raw sums rank the cores exactly as normalised rates and means would.

Top module: `tem_migration_ctrl`

## Requirements
- R1: An asynchronous active-low reset clears every counter, accumulator and the prediction history. While reset is held, swap_valid is 0 and both swap_src and swap_dst are 0.
- R2: Counting starts on the first clock edge after reset release. An interval ends after interval_len cycles, with values below 2 treated as 2. A core's emergency count for the interval is the number of cycles in which its emerg_pulse bit was 1.
- R3: For each core the predicted level is 2*E[n] - E[n-1]. E[n] is the count of the interval just ended and E[n-1] the count of the one before. Negative results become 0, and results above 2^CNT_W-1 saturate to that value.
- R4: swap_src is the core with the highest predicted level. Among equal values, the lowest core index wins.
- R5: swap_dst is the core with the smallest accumulated delay sum over the interval just ended. Among equal sums, the lowest core index wins.
- R6: No request is issued for an interval in which the chosen source and destination are the same core.
- R7: No request is issued for an interval in which the highest predicted level is 0. This holds even when some core recorded emergencies.
- R8: A request is a swap_valid pulse of exactly one cycle, in the second cycle of the following interval. swap_src and swap_dst carry the 2-bit core indices during that cycle and are 0 in every other cycle.
- R9: Emergency counters and delay accumulators restart from zero at each interval boundary. Activity in one interval does not enter the counts or sums of the next.
- R10: A delay sample is added only in a cycle where that core's dly_valid bit is 1. dly_sample values in other cycles have no effect.
- R11: A core's emergency count saturates at 2^CNT_W-1 within an interval and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| interval_len | input | INT_W | Migration interval length in cycles |
| emerg_pulse | input | 4 | Per-core timing-emergency pulse, bit c for core c |
| dly_valid | input | 4 | Per-core delay-sample valid, bit c for core c |
| dly_sample | input | 4*DLY_W | Per-core delay readings, core c at bits [c*DLY_W +: DLY_W] |
| swap_valid | output | 1 | One-cycle swap request strobe |
| swap_src | output | 2 | Index of the core expected to be most stressed |
| swap_dst | output | 2 | Index of the core with the most timing headroom |

## Verification
The bound checker watches every cycle. It confirms that a request never lasts two cycles and always follows an interval boundary by exactly two cycles. It also confirms that the indices are zero when no request is present, that source and destination differ, that the chosen source had a nonzero prediction, and that the destination's delay sum is no larger than the source's. Some behaviours only the directed scenarios can show, because they need a reference outcome. These are the ranking itself with its tie rules, the arithmetic of the prediction including its floor and ceiling, the counter saturation and clearing at boundaries, the rejection of samples without a valid flag, a changed interval length, and a reset that wipes the prediction history.

// File: rtl/tem_pkg.sv
package tem_pkg;
  localparam int unsigned CORES = 4;
  localparam int unsigned IDX_W = (CORES > 1) ? $clog2(CORES) : 1;

  typedef logic [IDX_W-1:0] core_idx_t;

  typedef struct packed {
    logic      valid;
    core_idx_t src;
    core_idx_t dst;
  } swap_req_t;
endpackage

// File: rtl/tem_interval_timer.sv
module tem_interval_timer #(
  parameter int unsigned INT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] interval_len,
  output logic             tick
);
  logic [INT_W-1:0] cnt_q, cnt_d;
  logic [INT_W-1:0] last_cnt;

  // Last cycle index of the interval; lengths below two are raised to two.
  always_comb begin
    if (interval_len < INT_W'(2)) last_cnt = INT_W'(1);
    else                          last_cnt = interval_len - INT_W'(1);
  end

  assign tick = (cnt_q >= last_cnt);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + INT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tem_lin_predictor.sv
module tem_lin_predictor #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] pred
);
  localparam int unsigned XW = W + 2;

  logic [XW-1:0] twice, base, diff;

  always_comb begin
    twice = {1'b0, cur, 1'b0};
    base  = {2'b00, prev};
    diff  = twice - base;
    if (twice <= base)          pred = '0;
    else if (diff[XW-1:W] != '0) pred = '1;
    else                         pred = diff[W-1:0];
  end
endmodule

// File: rtl/tem_core_monitor.sv
module tem_core_monitor #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned DLY_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             emerg,
  input  logic             dly_vld,
  input  logic [DLY_W-1:0] dly_smp,
  output logic [CNT_W-1:0] pred,
  output logic [ACC_W-1:0] dsum
);
  localparam int unsigned PAD_W = ACC_W + 1 - DLY_W;

  logic [CNT_W-1:0] ecnt_q, ecnt_d, ecnt_fin;
  logic [CNT_W-1:0] elast_q, elast_d;
  logic [CNT_W-1:0] eprev_q, eprev_d;
  logic [ACC_W-1:0] acc_q, acc_d, acc_fin;
  logic [ACC_W-1:0] dsum_q, dsum_d;
  logic [CNT_W:0]   esum;
  logic [ACC_W:0]   asum;

  // Saturating running totals including the current cycle's inputs.
  always_comb begin
    esum     = {1'b0, ecnt_q} + {{CNT_W{1'b0}}, emerg};
    ecnt_fin = esum[CNT_W] ? '1 : esum[CNT_W-1:0];
    asum     = {1'b0, acc_q} + (dly_vld ? {{PAD_W{1'b0}}, dly_smp} : '0);
    acc_fin  = asum[ACC_W] ? '1 : asum[ACC_W-1:0];
  end

  // Boundary acts as the load enable for the snapshot registers.
  always_comb begin
    ecnt_d  = ecnt_fin;
    acc_d   = acc_fin;
    elast_d = elast_q;
    eprev_d = eprev_q;
    dsum_d  = dsum_q;
    if (tick) begin
      ecnt_d  = '0;
      acc_d   = '0;
      elast_d = ecnt_fin;
      eprev_d = elast_q;
      dsum_d  = acc_fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q  <= '0;
      acc_q   <= '0;
      elast_q <= '0;
      eprev_q <= '0;
      dsum_q  <= '0;
    end else begin
      ecnt_q  <= ecnt_d;
      acc_q   <= acc_d;
      elast_q <= elast_d;
      eprev_q <= eprev_d;
      dsum_q  <= dsum_d;
    end
  end

  tem_lin_predictor #(.W(CNT_W)) u_pred (
    .cur  (elast_q),
    .prev (eprev_q),
    .pred (pred)
  );

  assign dsum = dsum_q;
endmodule

// File: rtl/tem_pair_select.sv
module tem_pair_select
  import tem_pkg::*;
#(
  parameter int unsigned PW = 20,
  parameter int unsigned SW = 24
) (
  input  logic [CORES*PW-1:0] pred_flat,
  input  logic [CORES*SW-1:0] sum_flat,
  output core_idx_t           hot_idx,
  output core_idx_t           cool_idx,
  output logic                pair_ok
);
  logic [PW-1:0] best_p;
  logic [SW-1:0] best_s;

  // Strict comparisons keep the lowest index on ties.
  always_comb begin
    best_p   = pred_flat[PW-1:0];
    best_s   = sum_flat[SW-1:0];
    hot_idx  = '0;
    cool_idx = '0;
    for (int i = 1; i < int'(CORES); i++) begin
      if (pred_flat[i*PW +: PW] > best_p) begin
        best_p  = pred_flat[i*PW +: PW];
        hot_idx = core_idx_t'(i);
      end
      if (sum_flat[i*SW +: SW] < best_s) begin
        best_s   = sum_flat[i*SW +: SW];
        cool_idx = core_idx_t'(i);
      end
    end
    pair_ok = (best_p != '0) && (hot_idx != cool_idx);
  end
endmodule

// File: rtl/tem_migration_ctrl.sv
module tem_migration_ctrl
  import tem_pkg::*;
#(
  parameter int unsigned INT_W = 24,
  parameter int unsigned CNT_W = 20,
  parameter int unsigned DLY_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INT_W-1:0]       interval_len,
  input  logic [CORES-1:0]       emerg_pulse,
  input  logic [CORES-1:0]       dly_valid,
  input  logic [CORES*DLY_W-1:0] dly_sample,
  output logic                   swap_valid,
  output logic [IDX_W-1:0]       swap_src,
  output logic [IDX_W-1:0]       swap_dst
);
  localparam int unsigned PRED_FLAT_W = CORES * CNT_W;
  localparam int unsigned SUM_FLAT_W  = CORES * ACC_W;

  logic                   bnd_tick;
  logic [PRED_FLAT_W-1:0] pred_flat;
  logic [SUM_FLAT_W-1:0]  dsum_flat;
  core_idx_t              sel_src, sel_dst;
  logic                   sel_ok;
  logic                   tick_d_q;
  swap_req_t              req_q, req_d;

  tem_interval_timer #(.INT_W(INT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .interval_len (interval_len),
    .tick         (bnd_tick)
  );

  for (genvar c = 0; c < int'(CORES); c++) begin : g_core
    tem_core_monitor #(
      .CNT_W (CNT_W),
      .DLY_W (DLY_W),
      .ACC_W (ACC_W)
    ) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bnd_tick),
      .emerg   (emerg_pulse[c]),
      .dly_vld (dly_valid[c]),
      .dly_smp (dly_sample[c*DLY_W +: DLY_W]),
      .pred    (pred_flat[c*CNT_W +: CNT_W]),
      .dsum    (dsum_flat[c*ACC_W +: ACC_W])
    );
  end

  tem_pair_select #(.PW(CNT_W), .SW(ACC_W)) u_sel (
    .pred_flat (pred_flat),
    .sum_flat  (dsum_flat),
    .hot_idx   (sel_src),
    .cool_idx  (sel_dst),
    .pair_ok   (sel_ok)
  );

  always_comb begin
    req_d = '0;
    if (tick_d_q && sel_ok) begin
      req_d.valid = 1'b1;
      req_d.src   = sel_src;
      req_d.dst   = sel_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d_q <= 1'b0;
      req_q    <= '0;
    end else begin
      tick_d_q <= bnd_tick;
      req_q    <= req_d;
    end
  end

  assign swap_valid = req_q.valid;
  assign swap_src   = req_q.src;
  assign swap_dst   = req_q.dst;
endmodule

// File: rtl/tem_swap_checker.sv
module tem_swap_checker
  import tem_pkg::*;
#(
  parameter int unsigned PW = 20,
  parameter int unsigned SW = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                swap_valid,
  input core_idx_t           swap_src,
  input core_idx_t           swap_dst,
  input logic [CORES*PW-1:0] pred_flat,
  input logic [CORES*SW-1:0] dsum_flat
);
  function automatic logic [PW-1:0] pick_p(input logic [CORES*PW-1:0] v, input core_idx_t i);
    return v[int'(i)*PW +: PW];
  endfunction

  function automatic logic [SW-1:0] pick_s(input logic [CORES*SW-1:0] v, input core_idx_t i);
    return v[int'(i)*SW +: SW];
  endfunction

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!swap_valid && swap_src == '0 && swap_dst == '0));

  assert_one_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |=> !swap_valid);

  assert_after_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> $past(tick, 2));

  assert_idle_indices_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_valid |-> (swap_src == '0 && swap_dst == '0));

  assert_distinct_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (swap_src != swap_dst));

  assert_source_stressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (pick_p($past(pred_flat), swap_src) != '0));

  assert_dest_not_slower_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (pick_s($past(dsum_flat), swap_dst) <= pick_s($past(dsum_flat), swap_src)));
endmodule

bind tem_migration_ctrl tem_swap_checker #(.PW(CNT_W), .SW(ACC_W)) u_swap_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (bnd_tick),
  .swap_valid (swap_valid),
  .swap_src   (swap_src),
  .swap_dst   (swap_dst),
  .pred_flat  (pred_flat),
  .dsum_flat  (dsum_flat)
);

// File: tb/tem_migration_ctrl_bench.sv
module tem_migration_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 4;
  localparam int CMAX       = (1 << CW) - 1;
  localparam int WD_CYCLES  = 150000;

  logic        clk;
  logic        rst_n;
  logic [23:0] interval_len;
  logic [3:0]  emerg_pulse;
  logic [3:0]  dly_valid;
  logic [31:0] dly_sample;
  logic        swap_valid;
  logic [1:0]  swap_src;
  logic [1:0]  swap_dst;

  tem_migration_ctrl #(.CNT_W(CW)) u_tem_migration_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .interval_len (interval_len),
    .emerg_pulse  (emerg_pulse),
    .dly_valid    (dly_valid),
    .dly_sample   (dly_sample),
    .swap_valid   (swap_valid),
    .swap_src     (swap_src),
    .swap_dst     (swap_dst)
  );

  int checks = 0;
  int fails  = 0;

  int cur_len = 40;
  int e_cnt[4];
  int d_val[4];
  int prev_m[4];
  int junk_core = -1;

  int obs_n, obs_pos, obs_src, obs_dst, obs_badidle;
  bit    pend_ok = 0;
  bit    pend_v;
  int    pend_s, pend_d;
  string pend_tag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cores(input int e0, e1, e2, e3, input int d0, d1, d2, d3);
    e_cnt[0] = e0; e_cnt[1] = e1; e_cnt[2] = e2; e_cnt[3] = e3;
    d_val[0] = d0; d_val[1] = d1; d_val[2] = d2; d_val[3] = d3;
  endtask

  // One interval of stimulus; also records what the outputs showed meanwhile.
  task automatic run_interval();
    obs_n = 0; obs_pos = -1; obs_src = 0; obs_dst = 0; obs_badidle = 0;
    for (int i = 0; i < cur_len; i++) begin
      @(negedge clk);
      if (swap_valid) begin
        obs_n++;
        if (obs_pos < 0) begin
          obs_pos = i; obs_src = int'(swap_src); obs_dst = int'(swap_dst);
        end
      end else if (swap_src != 2'd0 || swap_dst != 2'd0) begin
        obs_badidle++;
      end
      interval_len = 24'(cur_len);
      for (int c = 0; c < 4; c++) begin
        emerg_pulse[c] = (i < e_cnt[c]);
        dly_valid[c]   = (i % 10 == 0);
        if (i % 10 != 0 && junk_core == c) dly_sample[c*8 +: 8] = 8'd255;
        else                               dly_sample[c*8 +: 8] = 8'(d_val[c]);
      end
    end
  endtask

  // Reference outcome of the interval just driven, from the requirements.
  task automatic model_step(output bit v, output int s, output int d);
    int p[4];
    int cnt;
    for (int c = 0; c < 4; c++) begin
      cnt = (e_cnt[c] < cur_len) ? e_cnt[c] : cur_len;
      if (cnt > CMAX) cnt = CMAX;
      p[c] = 2 * cnt - prev_m[c];
      if (p[c] < 0) p[c] = 0;
      if (p[c] > CMAX) p[c] = CMAX;
      prev_m[c] = cnt;
    end
    s = 0; d = 0;
    for (int c = 1; c < 4; c++) begin
      if (p[c] > p[s]) s = c;
      if (d_val[c] < d_val[d]) d = c;
    end
    v = (p[s] != 0) && (s != d);
  endtask

  task automatic step(input string tag);
    run_interval();
    if (pend_ok) begin
      check(pend_tag, "R8 pulse count", obs_n, pend_v ? 1 : 0);
      check(pend_tag, "R8 indices zero when idle", obs_badidle, 0);
      if (pend_v && obs_n > 0) begin
        check(pend_tag, "R8 pulse position", obs_pos, 1);
        check(pend_tag, "source index", obs_src, pend_s);
        check(pend_tag, "destination index", obs_dst, pend_d);
      end
    end
    model_step(pend_v, pend_s, pend_d);
    pend_tag = tag;
    pend_ok  = 1;
  endtask

  task automatic idle_step();
    set_cores(0, 0, 0, 0, 20, 20, 20, 20);
    junk_core = -1;
    step("idle");
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    emerg_pulse = '0; dly_valid = '0; dly_sample = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(swap_valid), 0);
    check("R1", "src in reset", int'(swap_src), 0);
    check("R1", "dst in reset", int'(swap_dst), 0);
    for (int c = 0; c < 4; c++) prev_m[c] = 0;
    pend_ok = 0;
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic sc_basic();
    set_cores(3, 7, 2, 1, 50, 60, 40, 30);
    step("R2 R4 R5 basic pair");
    idle_step();
  endtask

  task automatic sc_predict();
    set_cores(10, 2, 0, 0, 40, 40, 40, 20);
    step("R3 first interval");
    set_cores(5, 4, 0, 0, 40, 40, 40, 20);
    step("R3 extrapolation overrides raw count");
    idle_step();
  endtask

  task automatic sc_tie_src();
    set_cores(0, 4, 4, 1, 10, 50, 50, 50);
    step("R4 tie on prediction");
    idle_step();
  endtask

  task automatic sc_tie_dst();
    set_cores(6, 0, 0, 0, 50, 20, 20, 30);
    step("R5 tie on delay sum");
    idle_step();
  endtask

  task automatic sc_same_core();
    set_cores(0, 0, 9, 1, 40, 40, 10, 40);
    step("R6 source equals destination");
    idle_step();
  endtask

  task automatic sc_zero_pred();
    set_cores(0, 8, 0, 0, 10, 40, 40, 40);
    step("R7 setup interval");
    set_cores(0, 3, 0, 0, 10, 40, 40, 40);
    step("R7 falling count predicts zero");
    idle_step();
  endtask

  task automatic sc_clear();
    set_cores(12, 0, 0, 0, 20, 20, 20, 20);
    step("R9 loaded interval");
    set_cores(0, 3, 0, 0, 20, 20, 10, 20);
    step("R9 fresh counts after boundary");
    idle_step();
  endtask

  task automatic sc_junk();
    set_cores(0, 5, 0, 0, 30, 40, 20, 30);
    junk_core = 2;
    step("R10 unflagged samples ignored");
    idle_step();
  endtask

  task automatic sc_saturate();
    set_cores(17, 6, 0, 0, 40, 40, 40, 10);
    step("R11 count saturation");
    idle_step();
  endtask

  task automatic sc_length();
    cur_len = 20;
    set_cores(2, 0, 5, 0, 10, 20, 30, 40);
    step("R2 shorter interval");
    idle_step();
  endtask

  task automatic sc_reset_history();
    cur_len = 40;
    idle_step();
    set_cores(0, 9, 0, 0, 10, 30, 30, 30);
    step("R1 before reset");
    apply_reset();
    set_cores(0, 4, 0, 0, 10, 30, 30, 30);
    step("R1 history cleared by reset");
    idle_step();
  endtask

  initial begin
    rst_n = 1'b1;
    interval_len = 24'd40;
    emerg_pulse = '0; dly_valid = '0; dly_sample = '0;
    for (int c = 0; c < 4; c++) prev_m[c] = 0;
    #2 rst_n = 1'b0;
    apply_reset();
    sc_basic();
    sc_predict();
    sc_tie_src();
    sc_tie_dst();
    sc_same_core();
    sc_zero_pred();
    sc_clear();
    sc_junk();
    sc_saturate();
    sc_length();
    sc_reset_history();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule